// File: doc/BRIEF.md
# Two-level TLB lookup sequencer

This block sequences the address translation of one processor memory request at a time. It does not hold translation entries and does not decode descriptors. It drives a lookup key to the TLB arrays and to a table walker around it, and it collects their answers. An accepted request goes first to the first-level TLB on its own side, instruction or data. If that lookup misses, the request goes to the shared second-level TLB. If that lookup also misses, the block asks for a table walk, but only when walks are allowed for the translation base that the address selects. Otherwise it answers with a translation fault.

Every lookup presents the same four-part key: the page-aligned virtual address, the address-space identifier, the virtual-machine identifier and the security space. A TLB reports a hit only when all four fields match one of its entries. The translation granule sets the page offset width, 4 KB or 64 KB. The result physical address takes the frame bits from the answering level and the offset bits from the request. The encoding of the table-cacheability field decides whether a walk fetch goes to the data cache or to external memory. When translation is switched off, the request's address comes back unchanged one cycle after acceptance.

The response carries a two-bit source tag and a bypass flag, so the user can see which level produced each result.

Top module: `xlat_lookup_seq`

## Requirements
- R1: When translation is on, an accepted request causes exactly one first-level lookup pulse in the cycle right after acceptance. The pulse goes on `l1i_lk_valid` when `req_instr` is 1 and on `l1d_lk_valid` when it is 0, and no other lookup is issued before the first-level response.
- R2: A second-level lookup (`l2_lk_valid`) is issued only after the first-level response reports a miss. A first-level hit ends the request with `rsp_src` = 2'b00 and no second-level lookup.
- R3: For the whole of a request, the lookup key outputs are the request's virtual address with the page offset bits cleared, its ASID, its VMID and its space bit. A difference in any one of the four fields turns an entry that would otherwise match into a miss.
- R4: A second-level hit ends the request with `rsp_src` = 2'b01 and no walk. A second-level miss, with translation on and walks allowed for the selected base, gives one `walk_req_valid` pulse and then `rsp_src` = 2'b10. `walk_base` is virtual address bit 63: 0 selects base 0 and 1 selects base 1.
- R5: If `cfg_walk_off[walk_base]` is 1 when the second-level lookup misses, the block issues no walk and responds with `rsp_src` = 2'b11 and `rsp_pa` = 0.
- R6: During a walk request, `walk_to_cache` is 1 when `cfg_tbl_attr` is 2'b01 (write-back). It is 0 for 2'b00 (non-cacheable), for 2'b10 (write-through) and for 2'b11.
- R7: The page offset is virtual address bits [11:0] when `cfg_gran64` = 0 and bits [15:0] when it is 1. `rsp_pa` is the answering level's address with its offset bits replaced by the request's offset bits.
- R8: With `cfg_mmu_en` = 0 at acceptance, the block issues no lookup and no walk. `rsp_valid` rises in the cycle after acceptance, with `rsp_pa` = virtual address [PA_W-1:0], `rsp_bypass` = 1 and `rsp_src` = 2'b00. A translated response has `rsp_bypass` = 0.
- R9: `req_ready` is 1 only while no request is in flight. A response stays valid and unchanged until `rsp_ready` is 1. The configuration inputs are sampled at acceptance, so later changes to them do not affect the request in flight.
- R10: After reset, `req_ready` = 1, `rsp_valid` = 0, and all lookup and walk request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Address-space identifier |
| req_vmid | input | VMID_W | Virtual-machine identifier |
| req_space | input | 1 | Security space of the access |
| req_instr | input | 1 | 1 for instruction fetch, 0 for data access |
| cfg_mmu_en | input | 1 | Translation enable |
| cfg_walk_off | input | 2 | Walk disable, one bit per translation base |
| cfg_gran64 | input | 1 | 1 selects the 64 KB granule, 0 the 4 KB granule |
| cfg_tbl_attr | input | 2 | Table-cacheability encoding |
| lk_va | output | VA_W | Key: page-aligned virtual address |
| lk_asid | output | ASID_W | Key: ASID |
| lk_vmid | output | VMID_W | Key: VMID |
| lk_space | output | 1 | Key: security space |
| l1i_lk_valid | output | 1 | Instruction first-level lookup pulse |
| l1i_rsp_valid | input | 1 | Instruction first-level answer valid |
| l1i_rsp_hit | input | 1 | Instruction first-level hit |
| l1i_rsp_pa | input | PA_W | Instruction first-level physical address |
| l1d_lk_valid | output | 1 | Data first-level lookup pulse |
| l1d_rsp_valid | input | 1 | Data first-level answer valid |
| l1d_rsp_hit | input | 1 | Data first-level hit |
| l1d_rsp_pa | input | PA_W | Data first-level physical address |
| l2_lk_valid | output | 1 | Second-level lookup pulse |
| l2_rsp_valid | input | 1 | Second-level answer valid |
| l2_rsp_hit | input | 1 | Second-level hit |
| l2_rsp_pa | input | PA_W | Second-level physical address |
| walk_req_valid | output | 1 | Table walk request pulse |
| walk_base | output | 1 | Selected translation base |
| walk_to_cache | output | 1 | 1 sends walk fetches to the data cache, 0 to external memory |
| walk_rsp_valid | input | 1 | Walk result valid |
| walk_rsp_pa | input | PA_W | Walk result physical address |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_pa | output | PA_W | Physical address, 0 on a fault |
| rsp_src | output | 2 | 00 first level, 01 second level, 10 walk, 11 fault |
| rsp_bypass | output | 1 | Translation was off for this request |

## Verification
On every cycle the assertions check the ordering rules. A first-level lookup follows acceptance directly, a second-level lookup follows a first-level miss, and a walk follows a second-level miss with translation on and the selected base allowed. They also check that at most one lookup is active at a time, that bypass responses rise one cycle after acceptance, and that a stalled response holds still. Only the bench scenarios can show the result values. These are the merged physical address under each granule, the effect of each key field on a hit, the cache or external-memory steering for every cacheability code, and the fault cases for each base. The bench scenarios also show that configuration changes after acceptance are ignored.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int OFF_SMALL = 12;
    localparam int OFF_LARGE = 16;
    localparam logic [1:0] ATTR_WB = 2'b01;

    typedef enum logic [1:0] {
        SRC_L1    = 2'd0,
        SRC_L2    = 2'd1,
        SRC_WALK  = 2'd2,
        SRC_FAULT = 2'd3
    } src_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ASK,
        ST_L1_WAIT,
        ST_L2_ASK,
        ST_L2_WAIT,
        ST_WK_ASK,
        ST_WK_WAIT,
        ST_RESP
    } seq_state_t;

    typedef struct packed {
        logic       mmu_en;
        logic [1:0] walk_off;
        logic       gran64;
        logic [1:0] attr;
    } xlat_cfg_t;

    function automatic logic attr_is_wb(input logic [1:0] attr);
        return attr == ATTR_WB;
    endfunction

endpackage

// File: rtl/xlat_key_unit.sv
module xlat_key_unit
    import xlat_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 48
) (
    input  logic [VA_W-1:0] va,
    input  logic            gran64,
    output logic [VA_W-1:0] page_va,
    output logic [PA_W-1:0] off_mask
);

    logic [VA_W-1:0] va_mask;

    for (genvar i = 0; i < VA_W; i++) begin : g_mask
        if (i < OFF_SMALL) begin : g_always
            assign va_mask[i] = 1'b1;
        end else if (i < OFF_LARGE) begin : g_large
            assign va_mask[i] = gran64;
        end else begin : g_never
            assign va_mask[i] = 1'b0;
        end
    end

    assign page_va  = va & ~va_mask;
    assign off_mask = va_mask[PA_W-1:0];

endmodule

// File: rtl/xlat_walk_route.sv
module xlat_walk_route
    import xlat_pkg::*;
(
    input  logic      va_top,
    input  xlat_cfg_t cfg,
    output logic      base_sel,
    output logic      walk_ok,
    output logic      to_cache
);

    assign base_sel = va_top;
    assign walk_ok  = cfg.mmu_en && !cfg.walk_off[base_sel];
    assign to_cache = attr_is_wb(cfg.attr);

endmodule

// File: rtl/xlat_seq_fsm.sv
module xlat_seq_fsm
    import xlat_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int PA_W   = 48,
    parameter int ASID_W = 16,
    parameter int VMID_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [VMID_W-1:0] req_vmid,
    input  logic              req_space,
    input  logic              req_instr,
    input  xlat_cfg_t         req_cfg,
    output logic [VA_W-1:0]   cap_va,
    output logic [ASID_W-1:0] cap_asid,
    output logic [VMID_W-1:0] cap_vmid,
    output logic              cap_space,
    output xlat_cfg_t         cap_cfg,
    input  logic [PA_W-1:0]   off_mask,
    input  logic              walk_ok,
    output logic              l1i_lk_valid,
    input  logic              l1i_rsp_valid,
    input  logic              l1i_rsp_hit,
    input  logic [PA_W-1:0]   l1i_rsp_pa,
    output logic              l1d_lk_valid,
    input  logic              l1d_rsp_valid,
    input  logic              l1d_rsp_hit,
    input  logic [PA_W-1:0]   l1d_rsp_pa,
    output logic              l2_lk_valid,
    input  logic              l2_rsp_valid,
    input  logic              l2_rsp_hit,
    input  logic [PA_W-1:0]   l2_rsp_pa,
    output logic              walk_req_valid,
    input  logic              walk_rsp_valid,
    input  logic [PA_W-1:0]   walk_rsp_pa,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_src,
    output logic              rsp_bypass
);

    seq_state_t      state;
    logic            cap_instr;
    logic [PA_W-1:0] res_pa;
    src_t            src_q;
    logic            byp_q;

    logic            l1_valid;
    logic            l1_hit;
    logic [PA_W-1:0] l1_pa;
    logic [PA_W-1:0] l1_merged;
    logic [PA_W-1:0] l2_merged;
    logic [PA_W-1:0] wk_merged;
    logic [PA_W-1:0] va_off;

    always_comb begin
        l1_valid  = cap_instr ? l1i_rsp_valid : l1d_rsp_valid;
        l1_hit    = cap_instr ? l1i_rsp_hit   : l1d_rsp_hit;
        l1_pa     = cap_instr ? l1i_rsp_pa    : l1d_rsp_pa;
        va_off    = cap_va[PA_W-1:0] & off_mask;
        l1_merged = (l1_pa       & ~off_mask) | va_off;
        l2_merged = (l2_rsp_pa   & ~off_mask) | va_off;
        wk_merged = (walk_rsp_pa & ~off_mask) | va_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cap_va    <= '0;
            cap_asid  <= '0;
            cap_vmid  <= '0;
            cap_space <= 1'b0;
            cap_instr <= 1'b0;
            cap_cfg   <= '0;
            res_pa    <= '0;
            src_q     <= SRC_L1;
            byp_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cap_va    <= req_va;
                        cap_asid  <= req_asid;
                        cap_vmid  <= req_vmid;
                        cap_space <= req_space;
                        cap_instr <= req_instr;
                        cap_cfg   <= req_cfg;
                        if (!req_cfg.mmu_en) begin
                            res_pa <= req_va[PA_W-1:0];
                            src_q  <= SRC_L1;
                            byp_q  <= 1'b1;
                            state  <= ST_RESP;
                        end else begin
                            byp_q  <= 1'b0;
                            state  <= ST_L1_ASK;
                        end
                    end
                end
                ST_L1_ASK: state <= ST_L1_WAIT;
                ST_L1_WAIT: begin
                    if (l1_valid) begin
                        if (l1_hit) begin
                            res_pa <= l1_merged;
                            src_q  <= SRC_L1;
                            state  <= ST_RESP;
                        end else begin
                            state  <= ST_L2_ASK;
                        end
                    end
                end
                ST_L2_ASK: state <= ST_L2_WAIT;
                ST_L2_WAIT: begin
                    if (l2_rsp_valid) begin
                        if (l2_rsp_hit) begin
                            res_pa <= l2_merged;
                            src_q  <= SRC_L2;
                            state  <= ST_RESP;
                        end else if (walk_ok) begin
                            state  <= ST_WK_ASK;
                        end else begin
                            res_pa <= '0;
                            src_q  <= SRC_FAULT;
                            state  <= ST_RESP;
                        end
                    end
                end
                ST_WK_ASK: state <= ST_WK_WAIT;
                ST_WK_WAIT: begin
                    if (walk_rsp_valid) begin
                        res_pa <= wk_merged;
                        src_q  <= SRC_WALK;
                        state  <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready      = (state == ST_IDLE);
    assign l1i_lk_valid   = (state == ST_L1_ASK) &&  cap_instr;
    assign l1d_lk_valid   = (state == ST_L1_ASK) && !cap_instr;
    assign l2_lk_valid    = (state == ST_L2_ASK);
    assign walk_req_valid = (state == ST_WK_ASK);
    assign rsp_valid      = (state == ST_RESP);
    assign rsp_pa         = res_pa;
    assign rsp_src        = src_q;
    assign rsp_bypass     = byp_q;

    // R1: first-level lookup directly follows acceptance
    assert_l1_first_R1: assert property (@(posedge clk) disable iff (rst)
        (l1i_lk_valid || l1d_lk_valid) |-> $past(req_valid && req_ready));

    // R2: second-level lookup only after a first-level miss
    assert_l2_after_miss_R2: assert property (@(posedge clk) disable iff (rst)
        l2_lk_valid |-> $past(l1_valid && !l1_hit));

    // R4: walk only after a second-level miss with translation on
    assert_walk_after_miss_R4: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid |-> ($past(l2_rsp_valid && !l2_rsp_hit) && cap_cfg.mmu_en));

    // R8: bypass answer rises one cycle after acceptance
    assert_bypass_latency_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && rsp_bypass) |-> $past(req_valid && req_ready));

    // R9: at most one lookup active, one request outstanding, response held
    assert_single_lookup_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({l1i_lk_valid, l1d_lk_valid, l2_lk_valid, walk_req_valid}));

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && rsp_valid));

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_src)));

endmodule

// File: rtl/xlat_lookup_seq.sv
module xlat_lookup_seq
    import xlat_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int PA_W   = 48,
    parameter int ASID_W = 16,
    parameter int VMID_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [VMID_W-1:0] req_vmid,
    input  logic              req_space,
    input  logic              req_instr,
    input  logic              cfg_mmu_en,
    input  logic [1:0]        cfg_walk_off,
    input  logic              cfg_gran64,
    input  logic [1:0]        cfg_tbl_attr,
    output logic [VA_W-1:0]   lk_va,
    output logic [ASID_W-1:0] lk_asid,
    output logic [VMID_W-1:0] lk_vmid,
    output logic              lk_space,
    output logic              l1i_lk_valid,
    input  logic              l1i_rsp_valid,
    input  logic              l1i_rsp_hit,
    input  logic [PA_W-1:0]   l1i_rsp_pa,
    output logic              l1d_lk_valid,
    input  logic              l1d_rsp_valid,
    input  logic              l1d_rsp_hit,
    input  logic [PA_W-1:0]   l1d_rsp_pa,
    output logic              l2_lk_valid,
    input  logic              l2_rsp_valid,
    input  logic              l2_rsp_hit,
    input  logic [PA_W-1:0]   l2_rsp_pa,
    output logic              walk_req_valid,
    output logic              walk_base,
    output logic              walk_to_cache,
    input  logic              walk_rsp_valid,
    input  logic [PA_W-1:0]   walk_rsp_pa,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_src,
    output logic              rsp_bypass
);

    xlat_cfg_t       req_cfg;
    xlat_cfg_t       cap_cfg;
    logic [VA_W-1:0] cap_va;
    logic [PA_W-1:0] off_mask;
    logic            walk_ok;

    assign req_cfg = '{mmu_en: cfg_mmu_en, walk_off: cfg_walk_off,
                       gran64: cfg_gran64, attr: cfg_tbl_attr};

    xlat_seq_fsm #(
        .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .VMID_W(VMID_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_asid(req_asid), .req_vmid(req_vmid),
        .req_space(req_space), .req_instr(req_instr), .req_cfg(req_cfg),
        .cap_va(cap_va), .cap_asid(lk_asid), .cap_vmid(lk_vmid),
        .cap_space(lk_space), .cap_cfg(cap_cfg),
        .off_mask(off_mask), .walk_ok(walk_ok),
        .l1i_lk_valid(l1i_lk_valid), .l1i_rsp_valid(l1i_rsp_valid),
        .l1i_rsp_hit(l1i_rsp_hit), .l1i_rsp_pa(l1i_rsp_pa),
        .l1d_lk_valid(l1d_lk_valid), .l1d_rsp_valid(l1d_rsp_valid),
        .l1d_rsp_hit(l1d_rsp_hit), .l1d_rsp_pa(l1d_rsp_pa),
        .l2_lk_valid(l2_lk_valid), .l2_rsp_valid(l2_rsp_valid),
        .l2_rsp_hit(l2_rsp_hit), .l2_rsp_pa(l2_rsp_pa),
        .walk_req_valid(walk_req_valid), .walk_rsp_valid(walk_rsp_valid),
        .walk_rsp_pa(walk_rsp_pa),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
        .rsp_src(rsp_src), .rsp_bypass(rsp_bypass)
    );

    xlat_key_unit #(.VA_W(VA_W), .PA_W(PA_W)) u_key (
        .va(cap_va), .gran64(cap_cfg.gran64),
        .page_va(lk_va), .off_mask(off_mask)
    );

    xlat_walk_route u_route (
        .va_top(cap_va[VA_W-1]), .cfg(cap_cfg),
        .base_sel(walk_base), .walk_ok(walk_ok), .to_cache(walk_to_cache)
    );

    // R5: a walk is never issued for a disabled base
    assert_no_walk_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid |-> !cap_cfg.walk_off[walk_base]);

    // R3: key stays fixed while a lookup is outstanding
    assert_key_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !$past(req_ready)) |-> ($stable(lk_va) && $stable(lk_asid)
                                               && $stable(lk_vmid) && $stable(lk_space)));

endmodule

// File: tb/test_xlat_lookup_seq.sv
`timescale 1ns/1ps
module test_xlat_lookup_seq;

    localparam int VA_W = 64;
    localparam int PA_W = 48;

    typedef struct packed {
        logic [63:0] va;
        logic [15:0] asid;
        logic [15:0] vmid;
        logic        space;
        logic        instr;
        logic        mmu;
        logic [1:0]  woff;
        logic        g64;
        logic [1:0]  attr;
        logic [1:0]  src;
    } vec_t;

    localparam logic [63:0] E1I_VA = 64'h0040_0000;
    localparam logic [47:0] E1I_PA = 48'h0000_1234_5000;
    localparam logic [63:0] E1D_VA = 64'h0080_0000;
    localparam logic [47:0] E1D_PA = 48'h0000_2222_0000;
    localparam logic [63:0] E2A_VA = 64'h0040_0000;
    localparam logic [47:0] E2A_PA = 48'h0000_AAAA_0000;
    localparam logic [63:0] E2B_VA = 64'h00C0_0000;
    localparam logic [47:0] E2B_PA = 48'h0000_BBBB_0000;
    localparam logic [47:0] WK_XOR = 48'h0000_5000_0000;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0040_0123, 16'd5, 16'd2, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 2'b01, 2'd0},
        '{64'h0000_0000_0080_0FFF, 16'd5, 16'd2, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 2'b01, 2'd0},
        '{64'h0000_0000_0040_0010, 16'd5, 16'd2, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 2'b01, 2'd1},
        '{64'h0000_0000_0040_0010, 16'd6, 16'd2, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 2'b01, 2'd2},
        '{64'h0000_0000_00C0_0020, 16'd5, 16'd2, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 2'b01, 2'd1},
        '{64'h0000_0000_00C0_0020, 16'd5, 16'd2, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 2'b10, 2'd2},
        '{64'h0000_0000_0040_0044, 16'd5, 16'd3, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 2'd2},
        '{64'h0000_0000_0900_0000, 16'd5, 16'd2, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 2'b01, 2'd3},
        '{64'h8000_0000_0900_0000, 16'd5, 16'd2, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 2'b11, 2'd2},
        '{64'h8000_0000_0900_0000, 16'd5, 16'd2, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 2'b01, 2'd3},
        '{64'h0000_0000_0900_0008, 16'd5, 16'd2, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 2'b01, 2'd2},
        '{64'h0000_0000_0040_ABCD, 16'd5, 16'd2, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 2'b01, 2'd0},
        '{64'h0000_0000_0040_ABCD, 16'd5, 16'd2, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 2'b01, 2'd2},
        '{64'h8000_1234_5678_9ABC, 16'd5, 16'd2, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 2'b01, 2'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic req_valid = 0, req_ready, req_space = 0, req_instr = 0;
    logic [63:0] req_va = '0;
    logic [15:0] req_asid = '0, req_vmid = '0;
    logic cfg_mmu_en = 0, cfg_gran64 = 0;
    logic [1:0] cfg_walk_off = '0, cfg_tbl_attr = '0;
    logic [63:0] lk_va;
    logic [15:0] lk_asid, lk_vmid;
    logic lk_space;
    logic l1i_lk_valid, l1d_lk_valid, l2_lk_valid, walk_req_valid, walk_base, walk_to_cache;
    logic l1i_rsp_valid, l1i_rsp_hit, l1d_rsp_valid, l1d_rsp_hit, l2_rsp_valid, l2_rsp_hit;
    logic walk_rsp_valid;
    logic [47:0] l1i_rsp_pa, l1d_rsp_pa, l2_rsp_pa, walk_rsp_pa;
    logic rsp_valid, rsp_ready = 0, rsp_bypass;
    logic [47:0] rsp_pa;
    logic [1:0] rsp_src;

    xlat_lookup_seq #(.VA_W(VA_W), .PA_W(PA_W)) i_xlat_lookup_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_asid(req_asid), .req_vmid(req_vmid),
        .req_space(req_space), .req_instr(req_instr),
        .cfg_mmu_en(cfg_mmu_en), .cfg_walk_off(cfg_walk_off),
        .cfg_gran64(cfg_gran64), .cfg_tbl_attr(cfg_tbl_attr),
        .lk_va(lk_va), .lk_asid(lk_asid), .lk_vmid(lk_vmid), .lk_space(lk_space),
        .l1i_lk_valid(l1i_lk_valid), .l1i_rsp_valid(l1i_rsp_valid),
        .l1i_rsp_hit(l1i_rsp_hit), .l1i_rsp_pa(l1i_rsp_pa),
        .l1d_lk_valid(l1d_lk_valid), .l1d_rsp_valid(l1d_rsp_valid),
        .l1d_rsp_hit(l1d_rsp_hit), .l1d_rsp_pa(l1d_rsp_pa),
        .l2_lk_valid(l2_lk_valid), .l2_rsp_valid(l2_rsp_valid),
        .l2_rsp_hit(l2_rsp_hit), .l2_rsp_pa(l2_rsp_pa),
        .walk_req_valid(walk_req_valid), .walk_base(walk_base),
        .walk_to_cache(walk_to_cache), .walk_rsp_valid(walk_rsp_valid),
        .walk_rsp_pa(walk_rsp_pa), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_pa(rsp_pa), .rsp_src(rsp_src), .rsp_bypass(rsp_bypass)
    );

    function automatic logic key_hit(input logic [63:0] va, input logic [15:0] asid,
                                     input logic [15:0] vmid, input logic space,
                                     input logic [63:0] eva, input logic espace);
        return (va == eva) && (asid == 16'd5) && (vmid == 16'd2) && (space == espace);
    endfunction

    // TLB and walker models: answer one cycle after each lookup pulse
    always @(posedge clk) begin
        if (rst) begin
            l1i_rsp_valid <= 0; l1d_rsp_valid <= 0; l2_rsp_valid <= 0; walk_rsp_valid <= 0;
            l1i_rsp_hit <= 0; l1d_rsp_hit <= 0; l2_rsp_hit <= 0;
            l1i_rsp_pa <= '0; l1d_rsp_pa <= '0; l2_rsp_pa <= '0; walk_rsp_pa <= '0;
        end else begin
            l1i_rsp_valid  <= l1i_lk_valid;
            l1i_rsp_hit    <= key_hit(lk_va, lk_asid, lk_vmid, lk_space, E1I_VA, 1'b0);
            l1i_rsp_pa     <= E1I_PA;
            l1d_rsp_valid  <= l1d_lk_valid;
            l1d_rsp_hit    <= key_hit(lk_va, lk_asid, lk_vmid, lk_space, E1D_VA, 1'b0);
            l1d_rsp_pa     <= E1D_PA;
            l2_rsp_valid   <= l2_lk_valid;
            l2_rsp_hit     <= key_hit(lk_va, lk_asid, lk_vmid, lk_space, E2A_VA, 1'b0) ||
                              key_hit(lk_va, lk_asid, lk_vmid, lk_space, E2B_VA, 1'b1);
            l2_rsp_pa      <= lk_space ? E2B_PA : E2A_PA;
            walk_rsp_valid <= walk_req_valid;
            walk_rsp_pa    <= lk_va[47:0] ^ WK_XOR;
        end
    end

    // Monitor: running totals and the last key / walk steering seen
    int n_l1i = 0, n_l1d = 0, n_l2 = 0, n_wk = 0;
    logic [63:0] seen_va;
    logic [15:0] seen_asid, seen_vmid;
    logic seen_space, seen_base, seen_cache;
    always @(negedge clk) begin
        if (l1i_lk_valid || l1d_lk_valid) begin
            seen_va = lk_va; seen_asid = lk_asid; seen_vmid = lk_vmid; seen_space = lk_space;
        end
        if (l1i_lk_valid) n_l1i++;
        if (l1d_lk_valid) n_l1d++;
        if (l2_lk_valid) n_l2++;
        if (walk_req_valid) begin
            n_wk++; seen_base = walk_base; seen_cache = walk_to_cache;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_pa(input vec_t v);
        logic [47:0] m, base;
        if (!v.mmu) return v.va[47:0];
        m = v.g64 ? 48'h0000_0000_FFFF : 48'h0000_0000_0FFF;
        case (v.src)
            2'd0: base = v.instr ? E1I_PA : E1D_PA;
            2'd1: base = v.space ? E2B_PA : E2A_PA;
            2'd2: base = (v.va[47:0] & ~m) ^ WK_XOR;
            default: return 48'h0;
        endcase
        return (base & ~m) | (v.va[47:0] & m);
    endfunction

    logic [1:0]  got_src;
    logic [47:0] got_pa;
    logic        got_byp;
    int          got_lat;
    bit          got_ok;

    task automatic send(input vec_t v, input int hold, input bit flip_cfg);
        int t;
        @(negedge clk);
        req_va = v.va; req_asid = v.asid; req_vmid = v.vmid;
        req_space = v.space; req_instr = v.instr;
        cfg_mmu_en = v.mmu; cfg_walk_off = v.woff; cfg_gran64 = v.g64; cfg_tbl_attr = v.attr;
        req_valid = 1;
        t = 0;
        while (!req_ready && t < 100) begin @(negedge clk); t++; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        if (flip_cfg) begin
            cfg_mmu_en = ~v.mmu; cfg_gran64 = ~v.g64;
            cfg_walk_off = ~v.woff; cfg_tbl_attr = ~v.attr;
        end
        got_lat = 1; t = 0;
        while (!rsp_valid && t < 200) begin @(negedge clk); got_lat++; t++; end
        got_ok = rsp_valid;
        if (!got_ok) begin
            chk("R9 response timeout", 64'd0, 64'd1);
            return;
        end
        got_src = rsp_src; got_pa = rsp_pa; got_byp = rsp_bypass;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R9 response held valid", {63'd0, rsp_valid}, 64'd1);
            chk("R9 response pa held", {16'd0, rsp_pa}, {16'd0, got_pa});
            chk("R9 req_ready low while busy", {63'd0, req_ready}, 64'd0);
        end
        rsp_ready = 1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 0;
    endtask

    task automatic run_vec(input int idx, input vec_t v);
        int b_l1i, b_l1d, b_l2, b_wk;
        string st;
        b_l1i = n_l1i; b_l1d = n_l1d; b_l2 = n_l2; b_wk = n_wk;
        send(v, 0, 1'b0);
        if (!got_ok) return;
        case (v.src)
            2'd0: st = "R2 src first level";
            2'd1: st = "R4 src second level";
            2'd2: st = "R4 src walk";
            default: st = "R5 src fault";
        endcase
        if (!v.mmu) st = "R8 src bypass";
        chk($sformatf("%s vec %0d", st, idx), {62'd0, got_src}, {62'd0, v.src});
        chk($sformatf("R7 pa vec %0d", idx), {16'd0, got_pa}, {16'd0, exp_pa(v)});
        chk($sformatf("R8 bypass flag vec %0d", idx), {63'd0, got_byp}, {63'd0, !v.mmu});
        chk($sformatf("R1 l1i lookups vec %0d", idx), 64'(n_l1i - b_l1i), 64'(v.mmu && v.instr));
        chk($sformatf("R1 l1d lookups vec %0d", idx), 64'(n_l1d - b_l1d), 64'(v.mmu && !v.instr));
        chk($sformatf("R2 l2 lookups vec %0d", idx), 64'(n_l2 - b_l2), 64'(v.mmu && v.src != 2'd0));
        chk($sformatf("R5 walk count vec %0d", idx), 64'(n_wk - b_wk), 64'(v.mmu && v.src == 2'd2));
        if (!v.mmu) begin
            chk($sformatf("R8 latency vec %0d", idx), 64'(got_lat), 64'd1);
        end else begin
            chk($sformatf("R3 key va vec %0d", idx), seen_va,
                v.va & ~(v.g64 ? 64'hFFFF : 64'hFFF));
            chk($sformatf("R3 key asid vec %0d", idx), {48'd0, seen_asid}, {48'd0, v.asid});
            chk($sformatf("R3 key vmid vec %0d", idx), {48'd0, seen_vmid}, {48'd0, v.vmid});
            chk($sformatf("R3 key space vec %0d", idx), {63'd0, seen_space}, {63'd0, v.space});
        end
        if (v.mmu && v.src == 2'd2) begin
            chk($sformatf("R6 walk_to_cache vec %0d", idx), {63'd0, seen_cache},
                {63'd0, v.attr == 2'b01});
            chk($sformatf("R4 walk_base vec %0d", idx), {63'd0, seen_base}, {63'd0, v.va[63]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        chk("R10 req_ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R10 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk("R10 lookups idle after reset",
            {60'd0, l1i_lk_valid, l1d_lk_valid, l2_lk_valid, walk_req_valid}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        // R9: stalled response holds, no new request taken
        send(VECS[2], 5, 1'b0);
        chk("R9 stalled src", {62'd0, got_src}, 64'd1);

        // R9: configuration changed after acceptance has no effect
        send(VECS[0], 0, 1'b1);
        chk("R9 cfg sampled src", {62'd0, got_src}, 64'd0);
        chk("R9 cfg sampled pa", {16'd0, got_pa}, {16'd0, exp_pa(VECS[0])});
        chk("R9 cfg sampled bypass", {63'd0, got_byp}, 64'd0);

        // R9: bypass with config flipped afterwards stays bypassed
        send(VECS[13], 0, 1'b1);
        chk("R9 bypass kept", {63'd0, got_byp}, 64'd1);
        chk("R8 bypass pa", {16'd0, got_pa}, {16'd0, VECS[13].va[47:0]});

        repeat (4) @(negedge clk);
        chk("R10 idle at end", {63'd0, req_ready}, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule